// File: doc/BRIEF.md
# Quadrature Counter Channel with Byte Interface

This block is a single channel of a position counter for incremental encoders. Two phase inputs, A and B, are decoded either as a quadrature pair at one, two or four counts per cycle, or as a step input on A with B giving the direction. The result drives a 24-bit up/down counter. A third input, the index, can reload the counter from a preset register, with a selectable active edge and an optional gate on the phase state.

A host reaches the channel through an 8-bit port with two addresses. At the control address, a write is a command byte and a read returns a status byte. At the data address, successive accesses step through the three bytes of a register, least significant byte first. Data writes fill the preset register and data reads drain an output latch. The counter itself is never written directly. Software places a value in the preset register and then issues a transfer command. To read a stable count, software first copies the counter into the latch and then reads the latch bytes.

Top module: `qcnt_channel`

## Requirements
- R1: After reset the counter, preset register, output latch, byte pointer, every flag and every configuration field are zero. With the phase-input enable (I/O register bit 0) clear, activity on A and B leaves the counter unchanged.
- R2: A data-address access reads or writes byte `p` of the latch or preset, where byte 0 is bits [7:0]. The pointer `p` then advances 0,1,2,0. Command bit 0 returns `p` to 0.
- R3: In a control write, bits [6:5] choose the target: 00 command, 01 count-mode register, 10 I/O register, 11 index register. Only the chosen target changes.
- R4: Command bit 3 copies the preset into the counter. Command bits [2:1]=01 clear the counter. Command bit 4 copies the counter into the latch, and later counting leaves the latch unchanged.
- R5: In the step/direction input mode (mode-register bits [4:3]=0), each rising edge of A counts up when B is 1 and down when B is 0. An input change shows in the counter three clock edges later.
- R6: Mode-register bits [4:3]=1, 2 and 3 select quadrature at x1, x2 and x4, giving 1, 2 and 4 counts per full A/B cycle. The sequence AB 00,10,11,01 counts up.
- R7: When A and B change in the same synchronized sample, no count is made and status bit 4 is set. Command bits [2:1]=11 clear status bit 4.
- R8: In count mode 0 (mode-register bits [2:1]), the counter wraps between 0xFFFFFF and 0. Each underflow flips status bit 0 and each overflow flips status bit 1. Command bits [2:1]=10 clear both bits.
- R9: In count mode 1, an up count with the counter equal to the preset is ignored, and a down count at 0 is ignored.
- R10: In count mode 2, the counter takes the wrapped value and then holds until a clear or a preset load.
- R11: In count mode 3, an up count at the preset value gives 0 and a down count at 0 gives the preset value.
- R12: The index loads the preset into the counter when I/O register bit 1 is 0. Index register bit 1 selects the active edge: 1 for rising, 0 for falling. Index register bit 0 admits the index only while A and B are both high, and this gate applies only in a quadrature input mode.
- R13: Status bit 5 shows the direction of the most recent count, with 1 meaning up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_sel | input | 1 | Address select: 1 control/status, 0 data |
| host_wr | input | 1 | Write strobe, one cycle per byte |
| host_rd | input | 1 | Read strobe, one cycle per byte |
| host_wdata | input | 8 | Write byte |
| host_rdata | output | 8 | Read byte: status or latch byte at the pointer |
| enc_a | input | 1 | Phase A (or step) input, asynchronous |
| enc_b | input | 1 | Phase B (or direction) input, asynchronous |
| enc_idx | input | 1 | Index input, asynchronous |

## Verification
The hardest states to reach are those at the edge of the count range, where a single encoder step must wrap, freeze, halt or reload depending on the count mode. The bench reaches them in only a few steps. It first writes a small preset and clears the counter. It then makes one backward step from zero, or counts up to the preset, so that every edge case occurs within a handful of transitions. The synchronous index gate needs the phase pair parked at 11 while the index edge arrives. To get there, the bench walks the quadrature sequence two steps forward and only then toggles the index. It also fires the same edge once at 00 to show that the gate blocks the load there.

// File: rtl/qcnt_pkg.sv
package qcnt_pkg;

  typedef enum logic [1:0] {CM_WRAP, CM_CLAMP, CM_ONCE, CM_MODN} cmode_e;
  typedef enum logic [1:0] {QD_STEPDIR, QD_X1, QD_X2, QD_X4} qmode_e;
  typedef enum logic [1:0] {TG_CMD, TG_MODE, TG_IO, TG_IDX} target_e;

  typedef struct packed {
    logic up;
    logic dn;
    logic bad;
  } step_t;

  // One synchronized sample of A/B against the previous one.
  function automatic step_t decode_step(qmode_e m, logic pa, logic pb, logic a, logic b);
    step_t r;
    logic ca, cb, fwd, take;
    r    = '0;
    ca   = pa ^ a;
    cb   = pb ^ b;
    fwd  = a ^ pb;
    take = (m == QD_X4) || (ca && ((m == QD_X2) || !b));
    if (m == QD_STEPDIR) begin
      if (!pa && a) begin
        r.up = b;
        r.dn = !b;
      end
    end else if (ca && cb) begin
      r.bad = 1'b1;
    end else if ((ca || cb) && take) begin
      r.up = fwd;
      r.dn = !fwd;
    end
    return r;
  endfunction

  function automatic logic index_edge(logic pos, logic prev, logic cur);
    return pos ? (!prev && cur) : (prev && !cur);
  endfunction

endpackage

// File: rtl/qcnt_input.sv
module qcnt_input
  import qcnt_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   a,
  input  logic   b,
  input  logic   idx,
  input  qmode_e qmode,
  input  logic   en,
  input  logic   idx_pos,
  input  logic   idx_sync,
  output logic   step_up,
  output logic   step_dn,
  output logic   noise,
  output logic   idx_evt
);

  logic [STAGES-1:0][2:0] stg;
  logic [2:0]             cur, prev;
  step_t                  st;
  logic                   gate_on, gate_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg  <= '0;
      prev <= '0;
    end else begin
      stg  <= {stg[STAGES-2:0], {idx, b, a}};
      prev <= cur;
    end
  end

  assign cur     = stg[STAGES-1];
  assign st      = decode_step(qmode, prev[0], prev[1], cur[0], cur[1]);
  assign step_up = en & st.up;
  assign step_dn = en & st.dn;
  assign noise   = en & st.bad;
  assign gate_on = idx_sync && (qmode != QD_STEPDIR);
  assign gate_ok = !gate_on || (cur[0] && cur[1]);
  assign idx_evt = index_edge(idx_pos, prev[2], cur[2]) && gate_ok;

  // R6
  step_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(step_up && step_dn));
  // R5
  stepdir_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (qmode == QD_STEPDIR && (step_up || step_dn)) |-> (cur[0] && !prev[0]));
  // R7
  noise_nocount_chk: assert property (@(posedge clk) disable iff (!rst_n)
    noise |-> !(step_up || step_dn));

endmodule

// File: rtl/qcnt_core.sv
module qcnt_core
  import qcnt_pkg::*;
#(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  cmode_e       mode,
  input  logic         step_up,
  input  logic         step_dn,
  input  logic         noise,
  input  logic         idx_load,
  input  logic         clr_cnt,
  input  logic         ld_preset,
  input  logic         clr_flags,
  input  logic         clr_err,
  input  logic [W-1:0] preset,
  output logic [W-1:0] cnt,
  output logic         borrow_t,
  output logic         carry_t,
  output logic         err,
  output logic         dir
);

  localparam logic [W-1:0] TOP = '1;
  localparam logic [W-1:0] ONE = W'(1);

  typedef struct packed {
    logic [W-1:0] val;
    logic         ovf;
    logic         unf;
    logic         halt;
  } nxt_t;

  function automatic nxt_t advance(cmode_e m, logic up, logic [W-1:0] c, logic [W-1:0] p);
    nxt_t r;
    r = '{val: c, ovf: 1'b0, unf: 1'b0, halt: 1'b0};
    if (up) begin
      if ((m == CM_CLAMP && c == p)) begin
        r.val = c;
      end else if (m == CM_MODN && c == p) begin
        r.val = '0;
        r.ovf = 1'b1;
      end else begin
        r.val  = c + ONE;
        r.ovf  = (c == TOP);
        r.halt = (m == CM_ONCE) && (c == TOP);
      end
    end else begin
      if (m == CM_CLAMP && c == '0) begin
        r.val = c;
      end else if (m == CM_MODN && c == '0) begin
        r.val = p;
        r.unf = 1'b1;
      end else begin
        r.val  = c - ONE;
        r.unf  = (c == '0);
        r.halt = (m == CM_ONCE) && (c == '0);
      end
    end
    return r;
  endfunction

  nxt_t nxt;
  logic halt_q, overridden, cnt_move;

  assign nxt        = advance(mode, step_up, cnt, preset);
  assign overridden = ld_preset || clr_cnt || idx_load;
  assign cnt_move   = (step_up || step_dn) && !halt_q && !overridden;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      halt_q   <= 1'b0;
      borrow_t <= 1'b0;
      carry_t  <= 1'b0;
      err      <= 1'b0;
      dir      <= 1'b0;
    end else begin
      if (ld_preset || idx_load) begin
        cnt    <= ld_preset ? preset : (clr_cnt ? '0 : preset);
        halt_q <= 1'b0;
      end else if (clr_cnt) begin
        cnt    <= '0;
        halt_q <= 1'b0;
      end else if (cnt_move) begin
        cnt    <= nxt.val;
        halt_q <= nxt.halt;
      end
      if (clr_flags) begin
        borrow_t <= 1'b0;
        carry_t  <= 1'b0;
      end else begin
        borrow_t <= borrow_t ^ (cnt_move & nxt.unf);
        carry_t  <= carry_t ^ (cnt_move & nxt.ovf);
      end
      if (step_up || step_dn) dir <= step_up;
      err <= noise | (err & ~clr_err);
    end
  end

  // R4
  preset_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_preset |=> (cnt == $past(preset)));
  // R4
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_cnt && !ld_preset) |=> (cnt == '0));
  // R9
  clamp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CM_CLAMP && step_up && cnt == preset && !overridden) |=> $stable(cnt));
  // R10
  once_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_q && !overridden) |=> $stable(cnt));
  // R8
  carry_only_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_flags && !step_up) |=> $stable(carry_t));
  // R7
  noise_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    noise |=> err);

endmodule

// File: rtl/qcnt_channel.sv
module qcnt_channel
  import qcnt_pkg::*;
#(
  parameter int W           = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_sel,
  input  logic       host_wr,
  input  logic       host_rd,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  input  logic       enc_a,
  input  logic       enc_b,
  input  logic       enc_idx
);

  localparam int NB  = W / 8;
  localparam int BPW = (NB > 1) ? $clog2(NB) : 1;
  localparam logic [BPW-1:0] BP_LAST = BPW'(NB - 1);

  target_e      tg;
  logic         ctl_wr, cmd_wr, data_acc;
  logic         clr_cnt, clr_flags, clr_err, ld_preset, grab, bp_rst;
  cmode_e       cmode_q;
  qmode_e       qmode_q;
  logic         ab_en_q, idx_hold_q, idx_sync_q, idx_pos_q;
  logic [W-1:0] preset_q, latch_q, cnt;
  logic [BPW-1:0] bp;
  logic [7:0]   rd_byte;
  logic         step_up, step_dn, noise, idx_evt;
  logic         borrow_t, carry_t, err, dir;
  logic         unused_bits;

  assign tg        = target_e'(host_wdata[6:5]);
  assign ctl_wr    = host_wr && host_sel;
  assign cmd_wr    = ctl_wr && (tg == TG_CMD);
  assign data_acc  = !host_sel && (host_wr || host_rd);
  assign clr_cnt   = cmd_wr && (host_wdata[2:1] == 2'b01);
  assign clr_flags = cmd_wr && (host_wdata[2:1] == 2'b10);
  assign clr_err   = cmd_wr && (host_wdata[2:1] == 2'b11);
  assign ld_preset = cmd_wr && host_wdata[3];
  assign grab      = cmd_wr && host_wdata[4];
  assign bp_rst    = cmd_wr && host_wdata[0];
  assign unused_bits = host_wdata[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmode_q    <= CM_WRAP;
      qmode_q    <= QD_STEPDIR;
      ab_en_q    <= 1'b0;
      idx_hold_q <= 1'b0;
      idx_sync_q <= 1'b0;
      idx_pos_q  <= 1'b0;
      preset_q   <= '0;
      latch_q    <= '0;
      bp         <= '0;
    end else begin
      if (ctl_wr) begin
        case (tg)
          TG_MODE: begin
            cmode_q <= cmode_e'(host_wdata[2:1]);
            qmode_q <= qmode_e'(host_wdata[4:3]);
          end
          TG_IO: begin
            ab_en_q    <= host_wdata[0];
            idx_hold_q <= host_wdata[1];
          end
          TG_IDX: begin
            idx_sync_q <= host_wdata[0];
            idx_pos_q  <= host_wdata[1];
          end
          default: ;
        endcase
      end
      if (grab) latch_q <= cnt;
      if (!host_sel && host_wr) begin
        for (int k = 0; k < NB; k++)
          if (bp == BPW'(k)) preset_q[k*8 +: 8] <= host_wdata;
      end
      if (bp_rst) bp <= '0;
      else if (data_acc) bp <= (bp == BP_LAST) ? '0 : bp + BPW'(1);
    end
  end

  always_comb begin
    rd_byte = '0;
    for (int k = 0; k < NB; k++)
      if (bp == BPW'(k)) rd_byte = latch_q[k*8 +: 8];
  end

  assign host_rdata = host_sel ? {2'b00, dir, err, 2'b00, carry_t, borrow_t} : rd_byte;

  qcnt_input #(.STAGES(SYNC_STAGES)) u_input (
    .clk      (clk),
    .rst_n    (rst_n),
    .a        (enc_a),
    .b        (enc_b),
    .idx      (enc_idx),
    .qmode    (qmode_q),
    .en       (ab_en_q),
    .idx_pos  (idx_pos_q),
    .idx_sync (idx_sync_q),
    .step_up  (step_up),
    .step_dn  (step_dn),
    .noise    (noise),
    .idx_evt  (idx_evt)
  );

  qcnt_core #(.W(W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (cmode_q),
    .step_up   (step_up),
    .step_dn   (step_dn),
    .noise     (noise),
    .idx_load  (idx_evt && !idx_hold_q),
    .clr_cnt   (clr_cnt),
    .ld_preset (ld_preset),
    .clr_flags (clr_flags),
    .clr_err   (clr_err),
    .preset    (preset_q),
    .cnt       (cnt),
    .borrow_t  (borrow_t),
    .carry_t   (carry_t),
    .err       (err),
    .dir       (dir)
  );

  // R2
  bp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bp <= BP_LAST);
  // R2
  bp_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_acc && !ctl_wr && bp == BP_LAST) |=> (bp == '0));
  // R3
  mode_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && tg == TG_MODE) |=> (cmode_q == $past(host_wdata[2:1])));
  // R4
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !grab |=> $stable(latch_q));

endmodule

// File: tb/tb_qcnt_channel.sv
`timescale 1ns/1ps
module tb_qcnt_channel;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel = 1'b1, wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       a = 1'b0, b = 1'b0, idx = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam int MAXV = 32'h00FF_FFFF;

  qcnt_channel dut (
    .clk(clk), .rst_n(rst_n), .host_sel(sel), .host_wr(wr), .host_rd(rd),
    .host_wdata(wdata), .host_rdata(rdata),
    .enc_a(a), .enc_b(b), .enc_idx(idx)
  );

  always #2 clk = ~clk;

  // reference model state
  bit ma1, mb1, mi1, ma2, mb2, mi2, mpa, mpb, mpi;
  int mcnt, mpre, mlat, mbp, mcm, mqm;
  bit mbor, mcar, merr, mdir, mhalt, men, mhold, msync, mpos;

  task automatic model_reset();
    {ma1, mb1, mi1, ma2, mb2, mi2, mpa, mpb, mpi} = '0;
    mcnt = 0; mpre = 0; mlat = 0; mbp = 0; mcm = 0; mqm = 0;
    {mbor, mcar, merr, mdir, mhalt, men, mhold, msync, mpos} = '0;
  endtask

  task automatic model_step();
    bit up, dn, bad, ie, ld_i, ca, cb, fw, take, syn, mv;
    bit cmd, grab, ldp, clc, clf, cle, bpr, ovf, unf, hl;
    int nv;
    if (!rst_n) begin model_reset(); return; end
    up = 0; dn = 0; bad = 0;
    ca = (mpa != ma2); cb = (mpb != mb2);
    if (mqm == 0) begin
      if (!mpa && ma2) begin up = mb2; dn = !mb2; end
    end else if (ca && cb) bad = 1;
    else if (ca || cb) begin
      fw = (ma2 != mpb);
      take = (mqm == 3) || (ca && (mqm == 2 || !mb2));
      up = take && fw; dn = take && !fw;
    end
    if (!men) begin up = 0; dn = 0; bad = 0; end
    syn  = msync && (mqm != 0);
    ie   = (mpos ? (!mpi && mi2) : (mpi && !mi2)) && (!syn || (ma2 && mb2));
    ld_i = ie && !mhold;
    cmd  = sel && wr && (wdata[6:5] == 2'b00);
    grab = cmd && wdata[4];
    ldp  = cmd && wdata[3];
    clc  = cmd && (wdata[2:1] == 2'b01);
    clf  = cmd && (wdata[2:1] == 2'b10);
    cle  = cmd && (wdata[2:1] == 2'b11);
    bpr  = cmd && wdata[0];
    nv = mcnt; ovf = 0; unf = 0; hl = 0;
    if (up) begin
      if (mcm == 1 && mcnt == mpre) nv = mcnt;
      else if (mcm == 3 && mcnt == mpre) begin nv = 0; ovf = 1; end
      else if (mcnt == MAXV) begin nv = 0; ovf = 1; hl = (mcm == 2); end
      else nv = mcnt + 1;
    end else if (dn) begin
      if (mcm == 1 && mcnt == 0) nv = 0;
      else if (mcm == 3 && mcnt == 0) begin nv = mpre; unf = 1; end
      else if (mcnt == 0) begin nv = MAXV; unf = 1; hl = (mcm == 2); end
      else nv = mcnt - 1;
    end
    mv = (up || dn) && !mhalt && !ldp && !clc && !ld_i;
    if (grab) mlat = mcnt;
    if (ldp) begin mcnt = mpre; mhalt = 0; end
    else if (clc) begin mcnt = 0; mhalt = 0; end
    else if (ld_i) begin mcnt = mpre; mhalt = 0; end
    else if (mv) begin mcnt = nv; mhalt = hl; end
    if (clf) begin mbor = 0; mcar = 0; end
    else begin
      if (mv && unf) mbor = !mbor;
      if (mv && ovf) mcar = !mcar;
    end
    if (up || dn) mdir = up;
    merr = bad || (merr && !cle);
    if (sel && wr) begin
      case (wdata[6:5])
        2'd1: begin mcm = wdata[2:1]; mqm = wdata[4:3]; end
        2'd2: begin men = wdata[0]; mhold = wdata[1]; end
        2'd3: begin msync = wdata[0]; mpos = wdata[1]; end
        default: ;
      endcase
    end
    if (!sel && wr) mpre = (mpre & ~(255 << (8 * mbp))) | (int'(wdata) << (8 * mbp));
    if (bpr) mbp = 0;
    else if (!sel && (wr || rd)) mbp = (mbp + 1) % 3;
    mpa = ma2; mpb = mb2; mpi = mi2;
    ma2 = ma1; mb2 = mb1; mi2 = mi1;
    ma1 = a; mb1 = b; mi1 = idx;
  endtask

  function automatic int model_rdata();
    if (sel) return {26'd0, mdir, merr, 2'b00, mcar, mbor};
    return (mlat >> (8 * mbp)) & 255;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // one clock: model advances, DUT edge, compare away from the edge
  task automatic cyc();
    model_step();
    @(posedge clk);
    @(negedge clk);
    chk(sel ? "R8 R13 status vs model" : "R2 latch byte vs model", int'(rdata), model_rdata());
  endtask

  task automatic idle(int n);
    sel = 1; wr = 0; rd = 0;
    repeat (n) cyc();
  endtask

  task automatic wctl(logic [7:0] v);
    sel = 1; wr = 1; wdata = v; cyc(); wr = 0;
  endtask

  task automatic wdat(logic [7:0] v);
    sel = 0; wr = 1; wdata = v; cyc(); wr = 0; sel = 1;
  endtask

  task automatic rdat(output logic [7:0] v);
    sel = 0; rd = 1; #1 v = rdata; cyc(); rd = 0; sel = 1;
  endtask

  task automatic getcnt(output int v);
    logic [7:0] b0, b1, b2;
    wctl(8'h11);
    rdat(b0); rdat(b1); rdat(b2);
    v = {8'd0, b2, b1, b0};
  endtask

  task automatic status(output int v);
    sel = 1; #1 v = int'(rdata);
  endtask

  task automatic setab(logic x, logic y);
    a = x; b = y; idle(4);
  endtask

  task automatic pulse_a(int n);
    for (int i = 0; i < n; i++) begin
      a = 1; idle(4); a = 0; idle(4);
    end
  endtask

  task automatic fwd(int n);
    for (int i = 0; i < n; i++) setab(!b, a);
  endtask

  task automatic bwd(int n);
    for (int i = 0; i < n; i++) setab(b, !a);
  endtask

  task automatic setpre(int v);
    wctl(8'h01); wdat(v[7:0]); wdat(v[15:8]); wdat(v[23:16]);
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int v;
    logic [7:0] bv;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle(2);
    status(v); chk("R1 status after reset", v, 0);
    getcnt(v); chk("R1 counter after reset", v, 0);
    pulse_a(3);
    getcnt(v); chk("R1 inputs disabled", v, 0);

    setpre(32'h123456); wctl(8'h08);
    getcnt(v); chk("R4 preset to counter", v, 32'h123456);
    rdat(bv); chk("R2 pointer wraps to byte 0", bv, 8'h56);

    wctl(8'h41); wctl(8'h20);
    b = 1; pulse_a(5);
    status(v); chk("R13 direction up", (v >> 5) & 1, 1);
    wctl(8'h01); rdat(bv); chk("R4 latch unchanged by counting", bv, 8'h56);
    getcnt(v); chk("R5 step up five", v, 32'h12345B);
    b = 0; pulse_a(2);
    getcnt(v); chk("R5 step down two", v, 32'h123459);
    status(v); chk("R13 direction down", (v >> 5) & 1, 0);

    wctl(8'h02); getcnt(v); chk("R4 clear counter", v, 0);
    setab(0, 0);
    wctl(8'h38); fwd(4);
    getcnt(v); chk("R3 R6 x4 cycle", v, 4);
    wctl(8'h28); fwd(4);
    getcnt(v); chk("R6 x1 cycle", v, 5);
    wctl(8'h30); fwd(4);
    getcnt(v); chk("R6 x2 cycle", v, 7);
    wctl(8'h38); bwd(4);
    getcnt(v); chk("R6 x4 backward", v, 3);

    setab(1, 1);
    status(v); chk("R7 error flag set", (v >> 4) & 1, 1);
    getcnt(v); chk("R7 no count on illegal step", v, 3);
    setab(0, 0);
    wctl(8'h06); idle(1);
    status(v); chk("R7 error flag cleared", (v >> 4) & 1, 0);

    wctl(8'h02); bwd(1);
    getcnt(v); chk("R8 underflow wraps", v, MAXV);
    status(v); chk("R8 borrow toggle", v & 3, 1);
    fwd(1);
    getcnt(v); chk("R8 overflow wraps", v, 0);
    status(v); chk("R8 carry toggle", v & 3, 3);
    wctl(8'h04); idle(1);
    status(v); chk("R8 toggles cleared", v & 3, 0);

    setpre(5); wctl(8'h22); wctl(8'h02);
    b = 1; pulse_a(7);
    getcnt(v); chk("R9 freezes at preset", v, 5);
    wctl(8'h02); b = 0; pulse_a(2);
    getcnt(v); chk("R9 freezes at zero", v, 0);

    wctl(8'h24); wctl(8'h02);
    b = 0; pulse_a(1);
    getcnt(v); chk("R10 wraps once", v, MAXV);
    status(v); chk("R10 borrow toggled", v & 1, 1);
    pulse_a(2);
    getcnt(v); chk("R10 holds after wrap", v, MAXV);
    wctl(8'h02); b = 1; pulse_a(1);
    getcnt(v); chk("R10 runs after clear", v, 1);

    wctl(8'h26); wctl(8'h02);
    b = 1; pulse_a(6);
    getcnt(v); chk("R11 up past preset gives zero", v, 0);
    b = 0; pulse_a(1);
    getcnt(v); chk("R11 down at zero gives preset", v, 5);

    wctl(8'h20); wctl(8'h02);
    idx = 1; idle(4);
    getcnt(v); chk("R12 rising edge ignored on negative polarity", v, 0);
    idx = 0; idle(4);
    getcnt(v); chk("R12 falling edge loads preset", v, 5);
    wctl(8'h62); wctl(8'h02);
    idx = 1; idle(4);
    getcnt(v); chk("R12 rising edge loads on positive polarity", v, 5);
    idx = 0; idle(4);
    wctl(8'h43); wctl(8'h02);
    idx = 1; idle(4);
    getcnt(v); chk("R12 index load disabled", v, 0);
    idx = 0; idle(4);

    wctl(8'h41); wctl(8'h38); wctl(8'h63);
    setab(0, 0); wctl(8'h02);
    idx = 1; idle(4);
    getcnt(v); chk("R12 sync gate blocks at AB 00", v, 0);
    idx = 0; idle(4);
    fwd(2);
    idx = 1; idle(4);
    getcnt(v); chk("R12 sync gate passes at AB 11", v, 5);
    idx = 0; idle(4);
    wctl(8'h20); setab(0, 0); wctl(8'h02);
    idx = 1; idle(4);
    getcnt(v); chk("R12 sync ignored in step mode", v, 5);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule